// File: doc/BRIEF.md
# Receiver Lock Acquisition Sequencer

This block steers how a data receiver settles onto an incoming signal. Two control bits come from software: an acquire request and a hold request. A one-cycle tick marks each received bit period. From these, the block selects the level-detector mode and the bit-sync loop bandwidth, and it drives a loop freeze line. While acquire is high the loop runs wide and the level detector tracks fast peaks. When acquire drops, the level detector moves to averaged peaks. The loop then spends a programmable number of bit periods at medium bandwidth before it settles at narrow bandwidth. If acquire was held for too few bit periods, a warning pulse flags the short acquisition.

The hold request freezes the loop through signal fades, so that lock is kept close when the signal returns. An active acquire request always overrides hold. A receiver powersave input parks the whole sequencer in an idle state with every output at its default. Software is expected to set it once after power-up.

Top module: `rx_acq_sequencer`

## Requirements
- R1: Whenever powersave is low, a high acquire input sampled at a clock edge makes the block show wide bandwidth (`pllBw` = 2'b10) and fast peak mode (`peakFast` = 1) from the next cycle on. This holds from any active state, including medium and narrow.
- R2: When acquire is sampled low after the block was in wide, the next cycle shows medium bandwidth (`pllBw` = 2'b01) and averaging peak mode (`peakFast` = 0).
- R3: Medium bandwidth lasts until MED_BITS counted bit ticks have been seen at clock edges in the medium state (default 30). The cycle after the edge holding the last counted tick shows narrow bandwidth (`pllBw` = 2'b00), and narrow then persists while acquire stays low.
- R4: `acqShortWarn` pulses high for exactly one cycle, together with the first medium cycle, when acquire falls after fewer than MIN_ACQ ticks (default 16) were counted at edges while already in wide. At MIN_ACQ or more ticks it stays low.
- R5: With acquire low and powersave low, a high hold input at an edge raises `pllFreeze` in the next cycle. A tick at that edge is not counted toward the medium duration.
- R6: While acquire is high, hold has no effect: `pllFreeze` stays 0 the cycle after.
- R7: Powersave high at an edge puts the block in idle in the next cycle, with `rxActive` = 0, `pllBw` = 2'b00, `peakFast` = 0, `pllFreeze` = 0 and `acqShortWarn` = 0. After powersave is released, the block enters wide if acquire is high and narrow otherwise.
- R8: Asynchronous active-low reset gives the same idle outputs as R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxPowerSave | input | 1 | 1 = receiver powersaved, sequencer idle |
| acqReq | input | 1 | Acquire request |
| holdReq | input | 1 | Hold (freeze) request |
| bitTick | input | 1 | One-cycle pulse per received bit period |
| rxActive | output | 1 | 1 when the sequencer is out of idle |
| peakFast | output | 1 | 1 = fast peak detect, 0 = averaging peak detect |
| pllBw | output | 2 | 2'b10 wide, 2'b01 medium, 2'b00 narrow |
| pllFreeze | output | 1 | Bit-sync loop freeze |
| acqShortWarn | output | 1 | One-cycle pulse on a too-short acquisition |

## Verification
Two situations are hardest to reach from the ports. The first is the exact boundary of the short-acquisition warning. The second is the medium-to-narrow handoff, which must be counted correctly while hold pauses some of the ticks. The bench sweeps the number of wide-phase ticks from zero up past the threshold, and drops acquire after each count. It then walks the medium phase tick by tick. In some runs, held ticks are mixed in, and the bench checks that bandwidth changes only on the last unheld tick. Re-acquisition from medium and narrow, and powersave taken in the middle of medium, are each driven on their own.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_WIDE   = 2'd1,
    S_MED    = 2'd2,
    S_NARROW = 2'd3
  } seqState_t;

  typedef enum logic [1:0] {
    BW_NARROW = 2'b00,
    BW_MED    = 2'b01,
    BW_WIDE   = 2'b10
  } pllBw_t;

  typedef struct packed {
    logic clrWide;
    logic incWide;
    logic clrMed;
    logic incMed;
  } cntStrobe_t;

endpackage

// File: rtl/acq_seq_count.sv
module acq_seq_count
  import acq_seq_pkg::*;
#(
  parameter int MIN_ACQ  = 16,
  parameter int MED_BITS = 30
) (
  input  logic       clk,
  input  logic       rstN,
  input  cntStrobe_t strobe,
  output logic       wideShort,
  output logic       medLast
);

  localparam int WideW = $clog2(MIN_ACQ + 1);
  localparam int MedW  = (MED_BITS > 1) ? $clog2(MED_BITS) : 1;
  localparam logic [WideW-1:0] WideSat  = WideW'(MIN_ACQ);
  localparam logic [MedW-1:0]  MedFinal = MedW'(MED_BITS - 1);

  logic [WideW-1:0] wideCnt;
  logic [MedW-1:0]  medCnt;

  // Wide-phase tick counter, saturating at the threshold
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wideCnt <= '0;
    end else if (strobe.clrWide) begin
      wideCnt <= '0;
    end else if (strobe.incWide && (wideCnt != WideSat)) begin
      wideCnt <= wideCnt + 1'b1;
    end
  end

  // Medium-phase tick counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      medCnt <= '0;
    end else if (strobe.clrMed) begin
      medCnt <= '0;
    end else if (strobe.incMed) begin
      medCnt <= medCnt + 1'b1;
    end
  end

  assign wideShort = (wideCnt < WideSat);
  assign medLast   = (medCnt == MedFinal);

  p_med_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    medCnt <= MedFinal);

  p_wide_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    wideCnt <= WideSat);

  p_inc_stops_at_last_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.incMed |-> !medLast);

endmodule

// File: rtl/acq_seq_ctrl.sv
module acq_seq_ctrl
  import acq_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxPowerSave,
  input  logic       acqReq,
  input  logic       holdReq,
  input  logic       bitTick,
  input  logic       wideShort,
  input  logic       medLast,
  output cntStrobe_t strobe,
  output logic       rxActive,
  output logic       peakFast,
  output logic [1:0] pllBw,
  output logic       pllFreeze,
  output logic       acqShortWarn
);

  seqState_t stateQ, stateD;
  logic      freezeQ, freezeD;
  logic      warnQ, warnD;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    if (rxPowerSave) begin
      stateD         = S_IDLE;
      strobe.clrWide = 1'b1;
      strobe.clrMed  = 1'b1;
    end else begin
      unique case (stateQ)
        S_IDLE: begin
          stateD         = acqReq ? S_WIDE : S_NARROW;
          strobe.clrWide = 1'b1;
          strobe.clrMed  = 1'b1;
        end
        S_WIDE: begin
          if (acqReq) begin
            strobe.incWide = bitTick;
          end else begin
            stateD        = S_MED;
            strobe.clrMed = 1'b1;
          end
        end
        S_MED: begin
          if (acqReq) begin
            stateD         = S_WIDE;
            strobe.clrWide = 1'b1;
          end else if (bitTick && !holdReq) begin
            if (medLast) begin
              stateD = S_NARROW;
            end else begin
              strobe.incMed = 1'b1;
            end
          end
        end
        S_NARROW: begin
          if (acqReq) begin
            stateD         = S_WIDE;
            strobe.clrWide = 1'b1;
          end
        end
        default: stateD = S_IDLE;
      endcase
    end
  end

  assign freezeD = !rxPowerSave && holdReq && !acqReq;
  assign warnD   = !rxPowerSave && (stateQ == S_WIDE) && !acqReq && wideShort;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= S_IDLE;
      freezeQ <= 1'b0;
      warnQ   <= 1'b0;
    end else begin
      stateQ  <= stateD;
      freezeQ <= freezeD;
      warnQ   <= warnD;
    end
  end

  always_comb begin
    unique case (stateQ)
      S_WIDE:  pllBw = BW_WIDE;
      S_MED:   pllBw = BW_MED;
      default: pllBw = BW_NARROW;
    endcase
  end

  assign rxActive     = (stateQ != S_IDLE);
  assign peakFast     = (stateQ == S_WIDE);
  assign pllFreeze    = freezeQ;
  assign acqShortWarn = warnQ;

  p_acq_wide_r1: assert property (@(posedge clk) disable iff (!rstN)
    (acqReq && !rxPowerSave) |=> (pllBw == BW_WIDE) && peakFast);

  p_fall_medium_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_WIDE && !acqReq && !rxPowerSave) |=> (pllBw == BW_MED) && !peakFast);

  p_narrow_after_med_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_NARROW && $past(stateQ) == S_MED) |-> $past(medLast && bitTick && !holdReq));

  p_warn_on_leave_r4: assert property (@(posedge clk) disable iff (!rstN)
    acqShortWarn |-> (stateQ == S_MED) && $past(stateQ) == S_WIDE);

  p_warn_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    acqShortWarn |=> !acqShortWarn);

  p_hold_freeze_r5: assert property (@(posedge clk) disable iff (!rstN)
    (holdReq && !acqReq && !rxPowerSave) |=> pllFreeze);

  p_acq_overrides_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    acqReq |=> !pllFreeze);

  p_powersave_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    rxPowerSave |=> !rxActive && !pllFreeze && !acqShortWarn && (pllBw == BW_NARROW) && !peakFast);

endmodule

// File: rtl/rx_acq_sequencer.sv
module rx_acq_sequencer
  import acq_seq_pkg::*;
#(
  parameter int MIN_ACQ  = 16,
  parameter int MED_BITS = 30
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxPowerSave,
  input  logic       acqReq,
  input  logic       holdReq,
  input  logic       bitTick,
  output logic       rxActive,
  output logic       peakFast,
  output logic [1:0] pllBw,
  output logic       pllFreeze,
  output logic       acqShortWarn
);

  cntStrobe_t strobe;
  logic       wideShort;
  logic       medLast;

  acq_seq_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .rxPowerSave  (rxPowerSave),
    .acqReq       (acqReq),
    .holdReq      (holdReq),
    .bitTick      (bitTick),
    .wideShort    (wideShort),
    .medLast      (medLast),
    .strobe       (strobe),
    .rxActive     (rxActive),
    .peakFast     (peakFast),
    .pllBw        (pllBw),
    .pllFreeze    (pllFreeze),
    .acqShortWarn (acqShortWarn)
  );

  acq_seq_count #(
    .MIN_ACQ  (MIN_ACQ),
    .MED_BITS (MED_BITS)
  ) u_count (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wideShort (wideShort),
    .medLast   (medLast)
  );

endmodule

// File: tb/sim_rx_acq_sequencer.sv
module sim_rx_acq_sequencer;

  localparam int MinAcq  = 16;
  localparam int MedBits = 30;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxPowerSave = 1'b1;
  logic       acqReq = 1'b0;
  logic       holdReq = 1'b0;
  logic       bitTick = 1'b0;
  logic       rxActive, peakFast, pllFreeze, acqShortWarn;
  logic [1:0] pllBw;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  rx_acq_sequencer #(.MIN_ACQ(MinAcq), .MED_BITS(MedBits)) u0 (
    .clk(clk), .rstN(rstN), .rxPowerSave(rxPowerSave), .acqReq(acqReq),
    .holdReq(holdReq), .bitTick(bitTick), .rxActive(rxActive),
    .peakFast(peakFast), .pllBw(pllBw), .pllFreeze(pllFreeze),
    .acqShortWarn(acqShortWarn)
  );

  task automatic check(input int actual, input int expected, input string tag);
    nChecks++;
    if (actual != expected) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic tick();
    bitTick = 1'b1;
    cyc();
    bitTick = 1'b0;
  endtask

  task automatic enterWide(input int n);
    acqReq = 1'b1;
    cyc();
    check(pllBw, 2, "R1 bw wide");
    check(peakFast, 1, "R1 fast peak");
    for (int i = 0; i < n; i++) tick();
    acqReq = 1'b0;
    cyc();
    check(pllBw, 1, "R2 bw medium");
    check(peakFast, 0, "R2 averaging peak");
    check(acqShortWarn, (n < MinAcq) ? 1 : 0, $sformatf("R4 warn n=%0d", n));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks + 1 - nFails, nChecks + 1);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R8 reset state
    check(rxActive, 0, "R8 active");
    check(pllBw, 0, "R8 bw");
    check(peakFast, 0, "R8 peak");
    check(pllFreeze, 0, "R8 freeze");
    check(acqShortWarn, 0, "R8 warn");
    rstN = 1'b1;
    cyc();
    check(rxActive, 0, "R7 powersave idle");
    rxPowerSave = 1'b0;
    cyc();
    check(rxActive, 1, "R7 release active");
    check(pllBw, 0, "R7 release narrow");

    // R4 warning sweep across the threshold, R3 medium duration
    for (int n = 0; n <= MinAcq + 3; n++) begin
      enterWide(n);
      cyc();
      check(acqShortWarn, 0, "R4 single pulse");
      for (int k = 1; k <= MedBits; k++) begin
        tick();
        check(pllBw, (k < MedBits) ? 1 : 0, $sformatf("R3 med k=%0d", k));
      end
      repeat (3) tick();
      check(pllBw, 0, "R3 narrow persists");
    end

    // R5 hold pauses medium count, mixed with counted ticks
    for (int h = 1; h <= 6; h++) begin
      enterWide(MinAcq);
      for (int k = 1; k < MedBits; k++) tick();
      holdReq = 1'b1;
      for (int j = 0; j < h; j++) tick();
      check(pllFreeze, 1, "R5 freeze");
      check(pllBw, 1, "R5 held ticks uncounted");
      holdReq = 1'b0;
      cyc();
      check(pllFreeze, 0, "R5 freeze release");
      tick();
      check(pllBw, 0, "R5 last unheld tick");
    end

    // R6 acquire overrides hold
    holdReq = 1'b1;
    acqReq  = 1'b1;
    cyc();
    check(pllFreeze, 0, "R6 freeze suppressed");
    check(pllBw, 2, "R6 wide");
    acqReq = 1'b0;
    cyc();
    check(pllFreeze, 1, "R5 freeze after acq drop");
    holdReq = 1'b0;

    // R1 re-acquire from medium
    acqReq = 1'b1;
    cyc();
    check(pllBw, 2, "R1 reacquire from medium");
    check(peakFast, 1, "R1 fast after medium");
    acqReq = 1'b0;
    cyc();
    repeat (5) tick();

    // R7 powersave mid-medium
    rxPowerSave = 1'b1;
    holdReq = 1'b1;
    cyc();
    check(rxActive, 0, "R7 idle");
    check(pllBw, 0, "R7 bw");
    check(peakFast, 0, "R7 peak");
    check(pllFreeze, 0, "R7 freeze");
    holdReq = 1'b0;
    acqReq = 1'b1;
    rxPowerSave = 1'b0;
    cyc();
    check(pllBw, 2, "R7 release into wide");
    check(rxActive, 1, "R7 active");
    acqReq = 1'b0;
    cyc();
    check(acqShortWarn, 1, "R4 warn zero ticks");

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule